// File: doc/BRIEF.md
# Three-State PWM Input Qualifier

This block sits between a switching controller's PWM line and a downstream dead-time controller. The analog front end reduces the PWM pin to two comparator flags: one set when the level is above the upper threshold, one set when it is below the lower threshold. The block synchronizes both flags and decodes the pin into three conditions: a request for the high-side switch, a request for the low-side switch, or a mid-level window. A mid-level window means the controller has let go of the line.

When the pin stays in the window for a programmable number of clock cycles, the block enters shutdown and forces both gate requests low. Shutdown ends as soon as the pin leaves the window. A shorter stay in the window leaves the last valid command in place.

A supply-monitor gate with hysteresis works alongside the decoder. Two more comparator flags report that the supply has crossed its rising threshold or has fallen below its falling threshold. While the supply is not good, both requests stay low and shutdown is re-armed. The block comes out of reset in shutdown, because the pin idles mid-level until the controller starts driving it.

Top module: `pwm3s_qualifier`

## Requirements
- R1: With only the upper flag set, the block requests the high side (`hiReq`=1, `loReq`=0). With only the lower flag set, it requests the low side (`hiReq`=0, `loReq`=1). Both hold only while `ready`=1 and `shutdown`=0.
- R2: Both flags set and both flags clear each decode as the mid-level window.
- R3: After `HOLD_CYCLES` consecutive synchronized samples in the window, `shutdown` goes to 1 and both requests go to 0.
- R4: A stay in the window of fewer than `HOLD_CYCLES` samples raises no shutdown and keeps the previous request. The holdoff count restarts each time the pin leaves the window.
- R5: On the first synchronized sample outside the window, `shutdown` clears and the new request is applied at the same clock edge.
- R6: While reset is asserted, and directly after it, `shutdown`=1, `ready`=0 and both requests are 0.
- R7: `ready` sets when the supply-rising flag is seen and clears when the supply-falling flag is seen. The falling flag wins when both are set. With neither flag set, `ready` keeps its value.
- R8: While `ready`=0, both requests are 0 and shutdown is re-armed. If the pin is in the window when `ready` returns, `shutdown` stays 1 with no new holdoff wait.
- R9: A change of a PWM flag reaches the outputs after three rising clock edges (two synchronizer stages plus one state register). A change of a supply flag reaches `ready` after the same three edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmAboveHi | input | 1 | Asynchronous flag: PWM level above upper threshold |
| pwmBelowLo | input | 1 | Asynchronous flag: PWM level below lower threshold |
| supRiseOk | input | 1 | Asynchronous flag: supply above rising threshold |
| supFallLow | input | 1 | Asynchronous flag: supply below falling threshold |
| hiReq | output | 1 | Request to turn on the high-side switch |
| loReq | output | 1 | Request to turn on the low-side switch |
| shutdown | output | 1 | Mid-level holdoff expired; both requests forced low |
| ready | output | 1 | Supply good; downstream stage may act |

## Verification
The hardest case to reach is the boundary of the holdoff. The pin must sit in the window for exactly one sample less than the holdoff, and must also leave just after the count has expired while the synchronizer still carries the old window level. The stimulus table gives each vector an explicit count of clock edges derived from `HOLD_CYCLES` and the three-edge latency, so these two edge cases fall on chosen cycles. Directed steps then walk the supply flags through their hysteresis band and bring `ready` back while the pin is mid-level, which exercises the re-armed shutdown.

// File: rtl/pwm3s_pkg.sv
package pwm3s_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_MID  = 2'd2
  } level_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic gateEn;
  } strobe_t;

endpackage

// File: rtl/pwm3s_sync.sv
module pwm3s_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/pwm3s_datapath.sv
module pwm3s_datapath
  import pwm3s_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    aboveSync,
  input  logic    belowSync,
  input  strobe_t strobe,
  output level_e  level,
  output logic    hiReq,
  output logic    loReq
);

  logic cmdHi;

  // R2: both or neither flag -> window
  always_comb begin
    unique case ({aboveSync, belowSync})
      2'b10:   level = LVL_HIGH;
      2'b01:   level = LVL_LOW;
      default: level = LVL_MID;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cmdHi <= 1'b0;
    else if (strobe.loadCmd) cmdHi <= (level == LVL_HIGH);
  end

  assign hiReq = strobe.gateEn & cmdHi;
  assign loReq = strobe.gateEn & ~cmdHi;

  a_r4_cmd_held_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_MID) |=> $stable(cmdHi));

  a_r1_cmd_follows_high: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_HIGH) |=> cmdHi);

  a_r1_cmd_follows_low: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_LOW) |=> !cmdHi);

endmodule

// File: rtl/pwm3s_ctrl.sv
module pwm3s_ctrl
  import pwm3s_pkg::*;
#(
  parameter int HOLD_CYCLES = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  level_e  level,
  input  logic    supRiseSync,
  input  logic    supFallSync,
  output strobe_t strobe,
  output logic    shutdown,
  output logic    ready
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          porOk;
  logic          shutReg;
  logic [CW-1:0] midCnt;
  logic          inWindow;

  assign inWindow = (level == LVL_MID);

  // R7: supply gate with hysteresis, falling flag has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            porOk <= 1'b0;
    else if (supFallSync) porOk <= 1'b0;
    else if (supRiseSync) porOk <= 1'b1;
  end

  // R3/R4/R5/R8: holdoff counter and shutdown state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutReg <= 1'b1;
      midCnt  <= LAST;
    end else if (!porOk) begin
      shutReg <= 1'b1;
      midCnt  <= LAST;
    end else if (!inWindow) begin
      shutReg <= 1'b0;
      midCnt  <= '0;
    end else begin
      shutReg <= (midCnt == LAST);
      if (midCnt != LAST) midCnt <= midCnt + 1'b1;
    end
  end

  assign strobe.loadCmd = !inWindow;
  assign strobe.gateEn  = porOk & ~shutReg;
  assign shutdown       = shutReg;
  assign ready          = porOk;

  a_r3_entry_needs_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutReg) |-> ($past(inWindow) || !$past(porOk)));

  a_r5_exit_at_once: assert property (@(posedge clk) disable iff (!rstN)
    (porOk && !inWindow) |=> !shutReg);

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    (!supFallSync && !supRiseSync) |=> $stable(porOk));

  a_r7_fall_wins: assert property (@(posedge clk) disable iff (!rstN)
    supFallSync |=> !porOk);

  a_r8_rearm: assert property (@(posedge clk) disable iff (!rstN)
    !porOk |=> shutReg);

endmodule

// File: rtl/pwm3s_qualifier.sv
module pwm3s_qualifier
  import pwm3s_pkg::*;
#(
  parameter int HOLD_CYCLES = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmAboveHi,
  input  logic pwmBelowLo,
  input  logic supRiseOk,
  input  logic supFallLow,
  output logic hiReq,
  output logic loReq,
  output logic shutdown,
  output logic ready
);

  localparam int NFLAGS = 4;

  logic [NFLAGS-1:0] flagsSync;
  level_e            level;
  strobe_t           strobe;

  pwm3s_sync #(.WIDTH(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({supFallLow, supRiseOk, pwmBelowLo, pwmAboveHi}),
    .dout (flagsSync)
  );

  pwm3s_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .aboveSync (flagsSync[0]),
    .belowSync (flagsSync[1]),
    .strobe    (strobe),
    .level     (level),
    .hiReq     (hiReq),
    .loReq     (loReq)
  );

  pwm3s_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .level       (level),
    .supRiseSync (flagsSync[2]),
    .supFallSync (flagsSync[3]),
    .strobe      (strobe),
    .shutdown    (shutdown),
    .ready       (ready)
  );

  a_r8_unready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (!hiReq && !loReq));

  a_r3_shutdown_quiet: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |-> (!hiReq && !loReq));

endmodule

// File: tb/pwm3s_qualifier_tb.sv
module pwm3s_qualifier_tb;

  localparam int H = 15;

  typedef struct packed {
    logic       a;
    logic       b;
    logic [7:0] n;
    logic       hi;
    logic       lo;
    logic       sd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd3,       1'b1, 1'b0, 1'b0, 4'd1}, // R1 high, R5 exit
    '{1'b0, 1'b1, 8'd3,       1'b0, 1'b1, 1'b0, 4'd1}, // R1 low
    '{1'b0, 1'b0, 8'd8,       1'b0, 1'b1, 1'b0, 4'd4}, // R4 short window
    '{1'b1, 1'b0, 8'd3,       1'b1, 1'b0, 1'b0, 4'd4}, // R4 restart
    '{1'b1, 1'b1, 8'(H + 1),  1'b1, 1'b0, 1'b0, 4'd4}, // R4 one short
    '{1'b1, 1'b1, 8'd1,       1'b0, 1'b0, 1'b1, 4'd3}, // R3 via R2 both
    '{1'b0, 1'b1, 8'd2,       1'b0, 1'b0, 1'b1, 4'd9}, // R9 latency
    '{1'b0, 1'b1, 8'd1,       1'b0, 1'b1, 1'b0, 4'd5}, // R5
    '{1'b0, 1'b0, 8'(H + 2),  1'b0, 1'b0, 1'b1, 4'd3}, // R3 neither
    '{1'b1, 1'b0, 8'd3,       1'b1, 1'b0, 1'b0, 4'd5}, // R5
    '{1'b0, 1'b0, 8'(H + 1),  1'b1, 1'b0, 1'b0, 4'd4}, // R4 one short
    '{1'b1, 1'b0, 8'd1,       1'b0, 1'b0, 1'b1, 4'd9}, // R9 in flight
    '{1'b1, 1'b0, 8'd2,       1'b1, 1'b0, 1'b0, 4'd5}  // R5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmAboveHi = 1'b0, pwmBelowLo = 1'b0;
  logic supRiseOk = 1'b0, supFallLow = 1'b0;
  logic hiReq, loReq, shutdown, ready;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm3s_qualifier #(.HOLD_CYCLES(H)) u_dut (
    .clk(clk), .rstN(rstN),
    .pwmAboveHi(pwmAboveHi), .pwmBelowLo(pwmBelowLo),
    .supRiseOk(supRiseOk), .supFallLow(supFallLow),
    .hiReq(hiReq), .loReq(loReq), .shutdown(shutdown), .ready(ready)
  );

  // compares {ready, hiReq, loReq, shutdown}
  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {ready, hiReq, loReq, shutdown};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s {ready,hi,lo,sd} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    edges(3);
    check("R6 in reset", 4'b0001);
    rstN = 1'b1;
    edges(1);
    check("R6 after reset", 4'b0001);
    supRiseOk = 1'b1;
    edges(3);
    check("R7 ready rises, R8 mid stays shut", 4'b1001);
    supRiseOk = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pwmAboveHi = VECS[i].a;
      pwmBelowLo = VECS[i].b;
      edges(int'(VECS[i].n));
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {1'b1, VECS[i].hi, VECS[i].lo, VECS[i].sd});
    end

    // R7/R8: supply falls while driving high
    supFallLow = 1'b1;
    edges(3);
    check("R7 fall clears ready, R8 outputs quiet", 4'b0000);
    edges(1);
    check("R8 shutdown re-armed", 4'b0001);
    supFallLow = 1'b0;
    edges(6);
    check("R7 hysteresis band holds not ready", 4'b0001);
    // R8: return with pin in window -> immediate shutdown
    pwmAboveHi = 1'b0;
    pwmBelowLo = 1'b0;
    supRiseOk = 1'b1;
    edges(3);
    check("R8 ready back in window", 4'b1001);
    supRiseOk = 1'b0;
    edges(3);
    check("R8 stays shut", 4'b1001);
    pwmBelowLo = 1'b1;
    edges(3);
    check("R1 low after R8", 4'b1010);
    // R7: both supply flags -> falling wins
    supRiseOk = 1'b1;
    supFallLow = 1'b1;
    edges(3);
    check("R7 fall priority", 4'b0000);
    supRiseOk = 1'b0;
    supFallLow = 1'b0;
    // R6: reset mid-run
    rstN = 1'b0;
    edges(1);
    check("R6 reset mid-run", 4'b0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule